// File: doc/BRIEF.md
# Sliding-Window SAD Pattern Trigger

This block watches a stream of 10-bit ADC samples and raises a trigger when the newest window of 128 samples closely resembles a stored reference waveform. Every accepted sample shifts into a 128-deep history. The block then pairs each history position with one reference entry and sums the absolute differences. When that sum is strictly below a programmable threshold, the block raises the trigger. A sum of zero means the window matches the reference exactly.

The reference is loaded one entry at a time through an address, data and write-strobe port. Address 0 pairs with the oldest sample in the window and address 127 pairs with the newest, so a waveform captured in time order can be written straight into ascending addresses. The difference-and-sum datapath is pipelined. Each sample's result, meaning the latest sum and the trigger decision, appears together a fixed number of cycles later and is held until the next result. Samples arrive at the full ADC rate with no decimation, and the block accepts one sample per clock.

Top module: `sad_match_trigger`

## Requirements
- R1: While reset is held and right after it is released, `sad_value` is 0, `trigger` is 0 and `sad_valid` is 0.
- R2: Each clock with `sample_valid` high yields exactly one `sad_valid` pulse, 9 clock edges after the edge that accepted the sample. `sad_valid` never pulses otherwise.
- R3: The window holds the 128 most recently accepted samples. Reference address k is compared with the sample accepted 127-k samples before the newest one, so address 127 pairs with the newest sample and address 0 with the oldest.
- R4: `sad_value` is the exact sum over all 128 positions of |window - reference|, 17 bits wide, with no overflow. For example, 128 samples of 1023 against an all-zero reference give 130944.
- R5: A result sets `trigger` to 1 exactly when its sum is strictly less than `threshold`. A sum equal to the threshold does not trigger, and a threshold of 0 never triggers.
- R6: Between results, `sad_value` and `trigger` hold their last values. A reference write is the one exception: it clears `trigger`.
- R7: No result triggers until 128 samples have been accepted since reset.
- R8: A reference write forces `trigger` to 0 on the following cycle. It restarts the 128-sample fill count, and results already in the pipeline when the write happens never trigger.
- R9: Clocks with `sample_valid` low leave the window unchanged, whatever `sample_data` carries.
- R10: Samples may arrive on every clock, and each one produces its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Qualifies `sample_data` for this clock |
| sample_data | input | 10 | ADC sample, unsigned |
| ref_we | input | 1 | Write strobe for one reference entry |
| ref_addr | input | 7 | Reference entry index (0 = oldest window position) |
| ref_data | input | 10 | Reference entry value |
| threshold | input | 17 | A sum strictly below this value triggers |
| sad_value | output | 17 | Latest sum of absolute differences |
| sad_valid | output | 1 | One-cycle pulse marking a new result |
| trigger | output | 1 | Match decision for the latest result |

## Verification
The hardest case to reach from the ports is a reference write that lands while a perfectly matching result is still inside the adder pipeline. That result must emerge with a sum of zero and yet not trigger. The stimulus first refills the window so that it matches the loaded reference. It then rewrites one reference entry with its unchanged value on the clock right after the last sample. This leaves the sum at zero and leaves the write's side effects as the only reason for the trigger to stay low. The fill-count restart and the 17-bit worst case (all 1023 against all zero) are reached the same way, by reloading the reference and streaming a full window.

// File: rtl/sad_pkg.sv
// Shared helpers for the sliding-window SAD trigger.
// Assumes the window depth is a power of two.
package sad_pkg;

    // Width needed to hold the sum of `count` values of `sample_w` bits.
    function automatic int sad_sum_width(input int sample_w, input int count);
        return sample_w + $clog2(count);
    endfunction

endpackage

// File: rtl/sad_window_buf.sv
// Sample history: a shift register of the last WINDOW accepted samples.
// Index 0 holds the oldest sample and index WINDOW-1 the newest.
// It also tracks how many samples have arrived since reset or since the
// last clear, and flags each accepted sample that completes a full window.
// Assumes that clear (a reference write) takes priority over the fill count.
module sad_window_buf #(
    parameter int SAMPLE_W = 10,
    parameter int WINDOW   = 128
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [SAMPLE_W-1:0]                in_data,
    input  logic                               clear_fill,
    output logic [WINDOW-1:0][SAMPLE_W-1:0]    win,
    output logic                               out_valid,
    output logic                               out_full
);
    localparam int CNT_W = $clog2(WINDOW + 1);

    logic [CNT_W-1:0] fill_cnt;

    // Shift the new sample in at the newest end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (in_valid) begin
            for (int i = 0; i < WINDOW - 1; i++) begin
                win[i] <= win[i+1];
            end
            win[WINDOW-1] <= in_data;
        end
    end

    // Count samples since reset or clear, saturating at WINDOW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (clear_fill) begin
            fill_cnt <= in_valid ? CNT_W'(1) : '0;
        end else if (in_valid && fill_cnt != CNT_W'(WINDOW)) begin
            fill_cnt <= fill_cnt + CNT_W'(1);
        end
    end

    // Tag the window state just produced: valid, and whether it is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_full  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_full  <= in_valid && !clear_fill && (fill_cnt >= CNT_W'(WINDOW - 1));
        end
    end

endmodule

// File: rtl/sad_ref_store.sv
// Reference waveform storage: WINDOW entries, written one at a time.
// Every entry is visible in parallel so the difference stage can read all of them.
// Assumes the address is always inside the window (power-of-two depth).
module sad_ref_store #(
    parameter int SAMPLE_W = 10,
    parameter int WINDOW   = 128,
    parameter int ADDR_W   = $clog2(WINDOW)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic [SAMPLE_W-1:0]                wr_data,
    output logic [WINDOW-1:0][SAMPLE_W-1:0]    refs
);

    // Write one entry and clear all of them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs <= '0;
        end else if (wr_en) begin
            refs[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/sad_diff_tree.sv
// Pipelined sum of absolute differences.
// Stage 0 registers |win[j] - refs[j]| for every position. Each of the
// log2(WINDOW) following stages registers pairwise sums, so the total
// appears 1 + log2(WINDOW) cycles after the inputs. A valid tag and a
// window-full tag travel with the data. The kill input drops the full tag
// of every stage so that in-flight results cannot trigger.
// Assumes WINDOW is a power of two and at least 2.
module sad_diff_tree #(
    parameter int SAMPLE_W = 10,
    parameter int WINDOW   = 128,
    parameter int SUM_W    = SAMPLE_W + $clog2(WINDOW)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [WINDOW-1:0][SAMPLE_W-1:0]    win,
    input  logic [WINDOW-1:0][SAMPLE_W-1:0]    refs,
    input  logic                               in_valid,
    input  logic                               in_full,
    input  logic                               kill,
    output logic [SUM_W-1:0]                   sum,
    output logic                               out_valid,
    output logic                               out_full
);
    localparam int LVLS = $clog2(WINDOW);

    logic [SAMPLE_W-1:0] leaf [WINDOW];
    logic                leaf_v;
    logic                leaf_f;

    // Absolute difference of every window/reference pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < WINDOW; j++) begin
                leaf[j] <= '0;
            end
            leaf_v <= 1'b0;
            leaf_f <= 1'b0;
        end else begin
            for (int j = 0; j < WINDOW; j++) begin
                leaf[j] <= (win[j] >= refs[j]) ? (win[j] - refs[j]) : (refs[j] - win[j]);
            end
            leaf_v <= in_valid;
            leaf_f <= in_full && !kill;
        end
    end

    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        localparam int N = WINDOW >> l;
        logic [SUM_W-1:0] s [N];
        logic             v;
        logic             f;

        if (l == 1) begin : g_first
            // First adder level: sum adjacent leaf differences.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int j = 0; j < N; j++) begin
                        s[j] <= '0;
                    end
                    v <= 1'b0;
                    f <= 1'b0;
                end else begin
                    for (int j = 0; j < N; j++) begin
                        s[j] <= SUM_W'(leaf[2*j]) + SUM_W'(leaf[2*j+1]);
                    end
                    v <= leaf_v;
                    f <= leaf_f && !kill;
                end
            end
        end else begin : g_next
            // Later adder levels: sum adjacent partial sums.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int j = 0; j < N; j++) begin
                        s[j] <= '0;
                    end
                    v <= 1'b0;
                    f <= 1'b0;
                end else begin
                    for (int j = 0; j < N; j++) begin
                        s[j] <= g_lvl[l-1].s[2*j] + g_lvl[l-1].s[2*j+1];
                    end
                    v <= g_lvl[l-1].v;
                    f <= g_lvl[l-1].f && !kill;
                end
            end
        end

        if (l == LVLS) begin : g_out
            assign sum       = s[0];
            assign out_valid = v;
            assign out_full  = f;
        end
    end

endmodule

// File: rtl/sad_match_trigger.sv
// Sliding-window SAD pattern trigger (top).
// Chains the sample history, the reference store and the pipelined
// difference tree, then registers the latest sum and the threshold
// decision together. The result of a sample appears 9 cycles after the
// edge that accepted it (default 128-deep window). A reference write
// clears the trigger and restarts the fill count.
// Assumes WINDOW is a power of two.
module sad_match_trigger #(
    parameter int SAMPLE_W = 10,
    parameter int WINDOW   = 128,
    parameter int ADDR_W   = $clog2(WINDOW),
    parameter int SUM_W    = sad_pkg::sad_sum_width(SAMPLE_W, WINDOW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic                ref_we,
    input  logic [ADDR_W-1:0]   ref_addr,
    input  logic [SAMPLE_W-1:0] ref_data,
    input  logic [SUM_W-1:0]    threshold,
    output logic [SUM_W-1:0]    sad_value,
    output logic                sad_valid,
    output logic                trigger
);

    logic [WINDOW-1:0][SAMPLE_W-1:0] win_bus;
    logic [WINDOW-1:0][SAMPLE_W-1:0] ref_bus;
    logic                            win_v;
    logic                            win_f;
    logic [SUM_W-1:0]                tree_sum;
    logic                            tree_v;
    logic                            tree_f;

    sad_window_buf #(
        .SAMPLE_W (SAMPLE_W),
        .WINDOW   (WINDOW)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (sample_valid),
        .in_data    (sample_data),
        .clear_fill (ref_we),
        .win        (win_bus),
        .out_valid  (win_v),
        .out_full   (win_f)
    );

    sad_ref_store #(
        .SAMPLE_W (SAMPLE_W),
        .WINDOW   (WINDOW),
        .ADDR_W   (ADDR_W)
    ) u_refs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ref_we),
        .wr_addr (ref_addr),
        .wr_data (ref_data),
        .refs    (ref_bus)
    );

    sad_diff_tree #(
        .SAMPLE_W (SAMPLE_W),
        .WINDOW   (WINDOW),
        .SUM_W    (SUM_W)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .win       (win_bus),
        .refs      (ref_bus),
        .in_valid  (win_v),
        .in_full   (win_f),
        .kill      (ref_we),
        .sum       (tree_sum),
        .out_valid (tree_v),
        .out_full  (tree_f)
    );

    // Publish each finished sum with its threshold decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sad_value <= '0;
            sad_valid <= 1'b0;
            trigger   <= 1'b0;
        end else begin
            sad_valid <= tree_v;
            if (tree_v) begin
                sad_value <= tree_sum;
            end
            if (ref_we) begin
                trigger <= 1'b0;
            end else if (tree_v) begin
                trigger <= tree_f && (tree_sum < threshold);
            end
        end
    end

endmodule

// File: rtl/sad_match_trigger_chk.sv
// Property checker for sad_match_trigger, attached by bind.
// It tracks accepted samples in a short shift register to check the
// result latency, and checks the hold, clear and bound rules at the ports.
module sad_match_trigger_chk #(
    parameter int SAMPLE_W = 10,
    parameter int WINDOW   = 128,
    parameter int SUM_W    = SAMPLE_W + $clog2(WINDOW)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             ref_we,
    input logic [SUM_W-1:0] threshold,
    input logic [SUM_W-1:0] sad_value,
    input logic             sad_valid,
    input logic             trigger
);
    localparam int LAT = $clog2(WINDOW) + 2;
    localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(WINDOW * ((1 << SAMPLE_W) - 1));

    logic [LAT:0] acc_pipe;

    // Delay line of accepted samples, used to predict result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_pipe <= '0;
        end else begin
            acc_pipe <= {acc_pipe[LAT-1:0], sample_valid};
        end
    end

    // R2
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sad_valid == acc_pipe[LAT]);

    // R5
    trigger_below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sad_valid && trigger) |-> (sad_value < $past(threshold)));

    // R6
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sad_valid |-> $stable(sad_value));

    // R6
    trigger_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sad_valid && !$past(ref_we)) |-> $stable(trigger));

    // R8
    ref_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_we |=> !trigger);

    // R4
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sad_value <= MAX_SUM);

endmodule

bind sad_match_trigger sad_match_trigger_chk #(
    .SAMPLE_W (SAMPLE_W),
    .WINDOW   (WINDOW),
    .SUM_W    (SUM_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .ref_we       (ref_we),
    .threshold    (threshold),
    .sad_value    (sad_value),
    .sad_valid    (sad_valid),
    .trigger      (trigger)
);

// File: tb/sad_match_trigger_tb_top.sv
// Self-checking bench for sad_match_trigger.
// It keeps its own model of the window and the reference, walks a table of
// samples and thresholds, then runs directed corner cases.
module sad_match_trigger_tb_top;
    localparam int W   = 128;
    localparam int LAT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [9:0]  sample_data = '0;
    logic        ref_we = 1'b0;
    logic [6:0]  ref_addr = '0;
    logic [9:0]  ref_data = '0;
    logic [16:0] threshold = '0;
    logic [16:0] sad_value;
    logic        sad_valid;
    logic        trigger;

    int n_checks = 0;
    int n_errs   = 0;
    int n_res    = 0;
    bit trig_seen = 0;

    int mwin [W];
    int mref [W];
    int mcount = 0;

    localparam int TBL_N = 7;
    localparam int TBL_X [TBL_N] = '{1016, 0, 1023, 500, 16, 8, 300};
    localparam int TBL_T [TBL_N] = '{1016, 131071, 0, 3000, 2200, 2300, 131071};

    sad_match_trigger dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .ref_we       (ref_we),
        .ref_addr     (ref_addr),
        .ref_data     (ref_data),
        .threshold    (threshold),
        .sad_value    (sad_value),
        .sad_valid    (sad_valid),
        .trigger      (trigger)
    );

    always #4 clk = ~clk;

    // Count results and note any trigger seen with them.
    always @(negedge clk) begin
        if (rst_n && sad_valid) begin
            n_res++;
            if (trigger) trig_seen = 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_sad();
        int s = 0;
        for (int i = 0; i < W; i++) begin
            s += (mwin[i] >= mref[i]) ? (mwin[i] - mref[i]) : (mref[i] - mwin[i]);
        end
        return s;
    endfunction

    function automatic void model_push(input int x);
        for (int i = 0; i < W - 1; i++) mwin[i] = mwin[i+1];
        mwin[W-1] = x;
        if (mcount < W) mcount++;
    endfunction

    // All stimulus tasks start and end at a falling edge.
    task automatic push(input int x);
        sample_valid = 1'b1;
        sample_data  = 10'(x);
        @(negedge clk);
        sample_valid = 1'b0;
        model_push(x);
    endtask

    task automatic stream(input int start, input int step, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            sample_valid = 1'b1;
            sample_data  = 10'(start + step * k);
            model_push(start + step * k);
            @(negedge clk);
        end
        sample_valid = 1'b0;
    endtask

    task automatic ref_write(input int a, input int d);
        ref_we   = 1'b1;
        ref_addr = 7'(a);
        ref_data = 10'(d);
        @(negedge clk);
        ref_we = 1'b0;
        mref[a] = d;
        mcount  = 0;
    endtask

    task automatic wait_result();
        for (int i = 0; i < 20; i++) begin
            if (sad_valid) break;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < W; i++) begin
            mwin[i] = 0;
            mref[i] = 0;
        end
        repeat (4) @(negedge clk);
        // R1: state during and after reset
        check("R1 sad_value in reset", int'(sad_value), 0);
        check("R1 trigger in reset", int'(trigger), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sad_valid after reset", int'(sad_valid), 0);
        check("R1 sad_value after reset", int'(sad_value), 0);

        // Load reference ramp in ascending address order (R3 ordering).
        for (int k = 0; k < W; k++) ref_write(k, 8 * k);
        threshold = 17'd1;

        // R7 and R10: 127 back-to-back samples, no trigger, one result each.
        n_res = 0;
        trig_seen = 0;
        stream(0, 8, W - 1);
        repeat (LAT + 3) @(negedge clk);
        check("R10 results per streamed sample", n_res, W - 1);
        check("R7 no trigger before full window", int'(trig_seen), 0);

        // R2 exact latency; R5 perfect match with threshold 1.
        push(1016);
        repeat (LAT - 1) @(negedge clk);
        check("R2 no result one cycle early", int'(sad_valid), 0);
        @(negedge clk);
        check("R2 result on the expected cycle", int'(sad_valid), 1);
        check("R5 perfect match sum", int'(sad_value), 0);
        check("R5 perfect match triggers", int'(trigger), 1);

        // Table walk: sample and threshold pairs against the model.
        for (int t = 0; t < TBL_N; t++) begin
            threshold = 17'(TBL_T[t]);
            push(TBL_X[t]);
            wait_result();
            check("R3/R4 table sum", int'(sad_value), model_sad());
            check("R5 table trigger", int'(trigger),
                  (mcount >= W && model_sad() < TBL_T[t]) ? 1 : 0);
            if (t == 0) check("R3 oldest-to-newest pairing", int'(sad_value), 1016);
            @(negedge clk);
        end

        // R9 and R6: invalid cycles carrying data change nothing.
        n_res = 0;
        for (int k = 0; k < 6; k++) begin
            sample_data = 10'(77 * k + 5);
            @(negedge clk);
        end
        check("R9 no result without valid", n_res, 0);
        check("R6 trigger held", int'(trigger), 1);
        check("R6 sum held", int'(sad_value), model_sad());
        push(640);
        wait_result();
        check("R9 window ignored invalid data", int'(sad_value), model_sad());
        @(negedge clk);

        // R8: a reference write clears the trigger on the next cycle.
        check("R8 trigger high before write", int'(trigger), 1);
        ref_write(0, 0);
        check("R8 trigger cleared by write", int'(trigger), 0);

        // R8: the fill count restarts after the write.
        threshold = 17'd131071;
        trig_seen = 0;
        stream(0, 8, W - 1);
        repeat (LAT + 3) @(negedge clk);
        check("R8 no trigger while refilling", int'(trig_seen), 0);

        // R8: a write while a matching result is in flight blocks its trigger.
        push(1016);
        ref_write(0, 0);
        wait_result();
        check("R8 in-flight sum still exact", int'(sad_value), 0);
        check("R8 in-flight result not triggered", int'(trigger), 0);
        @(negedge clk);

        // R4: worst-case sum without overflow.
        for (int k = 0; k < W; k++) ref_write(k, 0);
        stream(1023, 0, W);
        repeat (LAT + 3) @(negedge clk);
        check("R4 worst-case sum", int'(sad_value), 130944);
        check("R4 worst-case matches model", int'(sad_value), model_sad());
        check("R7 trigger after full refill", int'(trigger), 1);

        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule